// File: doc/BRIEF.md
# Tracking Position Counter with Busy, Direction and Revolution Strobes

This block holds the angular position word of a tracking converter. An abstract tracking loop, outside the block, decides when the measured angle has moved by one least significant bit and in which sense. It hands each such move over as a step on a valid/ready stream. The block applies the step to an up/down counter, announces it with a BUSY pulse of programmable width and drives a direction flag. It also raises a revolution flag whenever the count crosses its major carry.

The counter width is chosen by a resolution parameter: 10, 12, 14 or 16 active bits. The position port is always 16 bits wide, and the bits above the selected resolution read as zero. A hold input freezes the position port so that a reader can collect a stable word while counting goes on. Dropping the hold issues one extra BUSY pulse that loads the current count. Direction, BUSY and the revolution flag keep running while the hold is applied.

Back-pressure on the step stream works as follows. The producer keeps `step_valid` and `step_dir` steady until a cycle in which `step_ready` is high. A step is taken on that clock edge. `step_ready` then stays low until the BUSY pulse of that step has ended, and it is also low while a refresh pulse is pending. No step is ever dropped.

Top module: `trk_pos_counter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the count and `pos_q` to zero, drives `busy` and `ripple` low, sets `dir` to 1 (1 = up, 0 = down) and leaves `step_ready` high.
- R2: A step is taken at an edge where `step_valid` and `step_ready` are both high. `step_ready` is low from that edge until `busy` has fallen. A `step_valid` held high across the busy window therefore yields exactly one step per `BUSY_W+3` cycles.
- R3: A step with `step_dir`=1 adds one to the count and a step with `step_dir`=0 subtracts one, modulo 2^`RES_BITS`. Bits of `pos_q` at and above `RES_BITS` are always 0.
- R4: `busy` rises on the second edge after the accepting edge and stays high for exactly `BUSY_W` cycles. `pos_q` takes the new count on the same edge that `busy` rises, unless the hold is applied.
- R5: `dir` takes the value of the accepted step's `step_dir` on the accepting edge and keeps it through the next edge, so it changes before the revolution flag, BUSY and data of that step. At every other edge `dir` copies `sense_dir`, so it may toggle any number of times between steps without any count change.
- R6: A step from all ones up to zero, or from zero down to all ones, at the selected resolution raises `ripple` on the edge that updates the count. That is one cycle before `busy` rises.
- R7: Without a direction change while it is high, `ripple` stays high for exactly `RIP_MIN` cycles and then clears, before the next BUSY rising edge.
- R8: If `dir` changes while `ripple` is high, `ripple` stays high past `RIP_MIN`. It clears only after two BUSY rising edges with no further change of `dir`. Any new change restarts that count.
- R9: While `hold_latch` is 1, `pos_q` does not change. Steps, `busy`, `dir` and `ripple` behave as without the hold.
- R10: When `hold_latch` falls, a refresh BUSY pulse of `BUSY_W` cycles starts on the second edge after the fall, provided no step is in flight, and `pos_q` takes the current count on that edge. `step_ready` is low from the first edge after the fall until that pulse ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_valid | input | 1 | A one-LSB step is offered |
| step_ready | output | 1 | Block can take a step this cycle |
| step_dir | input | 1 | Sense of the offered step, 1 = up |
| sense_dir | input | 1 | Momentary rotation sense from the loop |
| hold_latch | input | 1 | 1 freezes the position output |
| pos_q | output | 16 | Latched position, upper unused bits zero |
| busy | output | 1 | Update strobe, one pulse per step or refresh |
| dir | output | 1 | Direction flag, 1 = up |
| ripple | output | 1 | Revolution flag set at the major carry |

## Verification
The bench aims at the carry in both senses at 12-bit resolution. A counter that wraps at the wrong width would show bits above bit 11 or miss the flag. It also reverses the sensed direction while the revolution flag is high and then toggles it back. A design that clears the flag by time alone, or that does not restart the stability count on the second change, drops the flag one step too early. A step valid held through the busy window would expose a design that takes steps during BUSY, because the count would run ahead. Releasing the hold checks that the frozen word is refreshed by its own pulse, and that stepping was not stopped while it was held.

// File: rtl/trk_pkg.sv
package trk_pkg;
  localparam int POS_W = 16;
  typedef logic [POS_W-1:0] pos_t;

  function automatic pos_t top_code(int res);
    return pos_t'((32'd1 << res) - 32'd1);
  endfunction

  function automatic bit res_ok(int res);
    return (res == 10) || (res == 12) || (res == 14) || (res == 16);
  endfunction
endpackage

// File: rtl/trk_step_seq.sv
module trk_step_seq #(
  parameter int BUSY_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic step_valid,
  input  logic step_dir,
  output logic step_ready,
  input  logic sense_dir,
  input  logic hold_latch,
  output logic upd_en,
  output logic upd_up,
  output logic busy_start,
  output logic busy,
  output logic dir
);
  localparam int BCW = $clog2(BUSY_W + 1);

  logic stage1_q, stage2_q, up_q, freeze_q, refresh_q, dir_q;
  logic [BCW-1:0] bcnt_q;
  logic idle, accept, refresh_go;

  assign idle       = !stage1_q && !stage2_q && (bcnt_q == '0);
  assign step_ready = idle && !refresh_q;
  assign accept     = step_valid && step_ready;
  assign refresh_go = refresh_q && idle;
  assign busy_start = stage2_q || refresh_go;
  assign busy       = (bcnt_q != '0);
  assign upd_en     = stage1_q;
  assign upd_up     = up_q;
  assign dir        = dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q  <= 1'b0;
      stage2_q  <= 1'b0;
      up_q      <= 1'b1;
      freeze_q  <= 1'b0;
      refresh_q <= 1'b0;
      dir_q     <= 1'b1;
      bcnt_q    <= '0;
    end else begin
      stage1_q <= accept;
      stage2_q <= stage1_q;
      if (accept) up_q <= step_dir;
      if (busy_start) bcnt_q <= BCW'(BUSY_W);
      else if (bcnt_q != '0) bcnt_q <= bcnt_q - 1'b1;
      // step sense wins at acceptance and is held while the count moves
      if (accept) dir_q <= step_dir;
      else if (!stage1_q) dir_q <= sense_dir;
      freeze_q <= hold_latch;
      if (freeze_q && !hold_latch) refresh_q <= 1'b1;
      else if (refresh_go) refresh_q <= 1'b0;
    end
  end

  assert_no_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
    busy |-> !step_ready);
  assert_dir_held_R5: assert property (@(posedge clk) disable iff (rst)
    stage1_q |=> (dir == $past(dir)));
  assert_busy_follows_R4: assert property (@(posedge clk) disable iff (rst)
    stage1_q |=> ##1 busy);
endmodule

// File: rtl/trk_pos_cnt.sv
module trk_pos_cnt
  import trk_pkg::*;
#(
  parameter int RES_BITS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic upd_en,
  input  logic upd_up,
  output pos_t count,
  output logic wrap_evt
);
  localparam pos_t MAXV = top_code(RES_BITS);

  pos_t cnt_q;
  logic at_top, at_bot;

  assign at_top   = (cnt_q == MAXV);
  assign at_bot   = (cnt_q == '0);
  assign wrap_evt = upd_en && (upd_up ? at_top : at_bot);
  assign count    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (upd_en) begin
      if (upd_up) cnt_q <= at_top ? '0 : cnt_q + 1'b1;
      else        cnt_q <= at_bot ? MAXV : cnt_q - 1'b1;
    end
  end

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= MAXV);
  assert_step_up_R3: assert property (@(posedge clk) disable iff (rst)
    (upd_en && upd_up && !at_top) |=> (cnt_q == pos_t'($past(cnt_q) + 1'b1)));
  assert_step_down_R3: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !upd_up && !at_bot) |=> (cnt_q == pos_t'($past(cnt_q) - 1'b1)));
endmodule

// File: rtl/trk_rev_flag.sv
module trk_rev_flag #(
  parameter int RIP_MIN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic wrap_evt,
  input  logic busy_evt,
  input  logic dir,
  output logic ripple
);
  localparam int MW = (RIP_MIN > 1) ? $clog2(RIP_MIN) : 1;

  logic rip_q, hold_q, prev_dir_q, dir_chg;
  logic [1:0] stab_q;
  logic [MW-1:0] min_q;

  assign dir_chg = (dir != prev_dir_q);
  assign ripple  = rip_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rip_q      <= 1'b0;
      hold_q     <= 1'b0;
      prev_dir_q <= 1'b1;
      stab_q     <= '0;
      min_q      <= '0;
    end else begin
      prev_dir_q <= dir;
      if (wrap_evt) begin
        rip_q  <= 1'b1;
        min_q  <= MW'(RIP_MIN - 1);
        hold_q <= 1'b0;
        stab_q <= '0;
      end else begin
        if (min_q != '0) min_q <= min_q - 1'b1;
        if (rip_q && dir_chg) begin
          hold_q <= 1'b1;
          stab_q <= '0;
        end else begin
          if (hold_q && busy_evt && stab_q != 2'd2) stab_q <= stab_q + 1'b1;
          if (rip_q && min_q == '0 && (!hold_q || stab_q == 2'd2)) begin
            rip_q  <= 1'b0;
            hold_q <= 1'b0;
            stab_q <= '0;
          end
        end
      end
    end
  end

  assert_wrap_sets_R6: assert property (@(posedge clk) disable iff (rst)
    wrap_evt |=> ripple);
  assert_reversal_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (rip_q && hold_q && stab_q != 2'd2) |=> ripple);
  assert_no_early_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (rip_q && min_q != '0) |=> ripple);
endmodule

// File: rtl/trk_pos_counter.sv
module trk_pos_counter
  import trk_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int BUSY_W   = 4,
  parameter int RIP_MIN  = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        step_valid,
  output logic        step_ready,
  input  logic        step_dir,
  input  logic        sense_dir,
  input  logic        hold_latch,
  output logic [15:0] pos_q,
  output logic        busy,
  output logic        dir,
  output logic        ripple
);
  initial begin
    assert (res_ok(RES_BITS)) else $error("RES_BITS must be 10, 12, 14 or 16");
    assert (BUSY_W >= 1 && RIP_MIN >= 1 && RIP_MIN < BUSY_W + 4)
      else $error("pulse width parameters out of range");
  end

  logic upd_en, upd_up, busy_start, wrap_evt;
  pos_t count, pos_r;

  trk_step_seq #(.BUSY_W(BUSY_W)) u_seq (
    .clk(clk), .rst(rst), .step_valid(step_valid), .step_dir(step_dir),
    .step_ready(step_ready), .sense_dir(sense_dir), .hold_latch(hold_latch),
    .upd_en(upd_en), .upd_up(upd_up), .busy_start(busy_start),
    .busy(busy), .dir(dir)
  );

  trk_pos_cnt #(.RES_BITS(RES_BITS)) u_cnt (
    .clk(clk), .rst(rst), .upd_en(upd_en), .upd_up(upd_up),
    .count(count), .wrap_evt(wrap_evt)
  );

  trk_rev_flag #(.RIP_MIN(RIP_MIN)) u_rev (
    .clk(clk), .rst(rst), .wrap_evt(wrap_evt), .busy_evt(busy_start),
    .dir(dir), .ripple(ripple)
  );

  always_ff @(posedge clk) begin
    if (rst) pos_r <= '0;
    else if (busy_start && !hold_latch) pos_r <= count;
  end

  assign pos_q = pos_r;

  assert_latch_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    hold_latch |=> $stable(pos_q));
  assert_ripple_before_busy_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ripple) |-> !busy);
endmodule

// File: tb/sim_trk_pos_counter.sv
module sim_trk_pos_counter;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 4;
  localparam int RM = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_valid = 1'b0, step_dir = 1'b1, sense_dir = 1'b1, hold_latch = 1'b0;
  logic step_ready, busy, dir, ripple;
  logic [15:0] pos_q;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trk_pos_counter #(.RES_BITS(12), .BUSY_W(BW), .RIP_MIN(RM)) u0 (
    .clk(clk), .rst(rst), .step_valid(step_valid), .step_ready(step_ready),
    .step_dir(step_dir), .sense_dir(sense_dir), .hold_latch(hold_latch),
    .pos_q(pos_q), .busy(busy), .dir(dir), .ripple(ripple)
  );

  // {dir, wrap expected, resulting position}
  localparam logic [17:0] VEC [8] = '{
    18'h20001, 18'h20002, 18'h00001, 18'h00000,
    18'h10FFF, 18'h30000, 18'h20001, 18'h00000
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // one step; starts in an idle cycle, ends one cycle after busy fell
  task automatic do_step(input logic d, input logic [15:0] exp_pos, input logic wrap,
                         input bit chk_pos, input bit chk_rip);
    step_valid = 1'b1; step_dir = d; sense_dir = d;
    @(negedge clk);
    chk("R2 ready low after accept", step_ready, 0);
    chk("R5 dir set at accept", dir, d);
    step_valid = 1'b0;
    @(negedge clk);
    if (chk_rip) chk("R6 ripple on count update", ripple, wrap);
    chk("R4 busy not yet", busy, 0);
    @(negedge clk);
    chk("R4 busy rises", busy, 1);
    if (chk_pos) chk("R3 position", pos_q, exp_pos);
    for (int k = 3; k <= 6; k++) begin
      @(negedge clk);
      chk("R4 busy width", busy, (k <= BW + 1) ? 1 : 0);
      if (chk_rip) chk("R7 ripple width", ripple, (wrap && k <= RM) ? 1 : 0);
    end
    chk("R2 ready back", step_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int rises;
    logic prev_b;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 pos reset", pos_q, 0);
    chk("R1 busy reset", busy, 0);
    chk("R1 ripple reset", ripple, 0);
    chk("R1 dir reset", dir, 1);
    chk("R1 ready reset", step_ready, 1);

    for (int i = 0; i < 8; i++)
      do_step(VEC[i][17], VEC[i][15:0], VEC[i][16], 1'b1, 1'b1);

    // R5: sub-LSB direction toggles move dir only
    for (int i = 0; i < 4; i++) begin
      sense_dir = i[0];
      @(negedge clk);
      chk("R5 dir follows sense", dir, i[0]);
      chk("R5 no busy on toggle", busy, 0);
    end
    chk("R5 position unchanged", pos_q, 0);

    // R8: reversal while ripple high, then a second reversal
    step_valid = 1'b1; step_dir = 1'b0; sense_dir = 1'b0;
    @(negedge clk);
    step_valid = 1'b0; sense_dir = 1'b1;
    @(negedge clk);
    chk("R5 dir held during update", dir, 0);
    chk("R6 ripple down wrap", ripple, 1);
    @(negedge clk);
    chk("R5 dir follows sense after update", dir, 1);
    repeat (4) @(negedge clk);
    chk("R8 ripple held after reversal", ripple, 1);
    sense_dir = 1'b0;
    @(negedge clk);
    chk("R8 dir back down", dir, 0);
    repeat (2) @(negedge clk);
    chk("R8 ripple still held", ripple, 1);
    do_step(1'b0, 16'h0FFE, 1'b0, 1'b1, 1'b0);
    chk("R8 held after one stable busy", ripple, 1);
    do_step(1'b0, 16'h0FFD, 1'b0, 1'b1, 1'b0);
    chk("R8 cleared after two stable busy", ripple, 0);

    // R9/R10: hold freezes pos_q, release refreshes it
    hold_latch = 1'b1;
    @(negedge clk);
    do_step(1'b1, 16'h0, 1'b0, 1'b0, 1'b1);
    chk("R9 pos frozen", pos_q, 16'h0FFD);
    chk("R9 ripple unaffected", ripple, 0);
    hold_latch = 1'b0;
    @(negedge clk);
    chk("R10 ready low after release", step_ready, 0);
    chk("R10 busy not yet", busy, 0);
    @(negedge clk);
    chk("R10 refresh busy", busy, 1);
    chk("R10 refreshed pos", pos_q, 16'h0FFE);
    repeat (BW) @(negedge clk);
    chk("R10 refresh ends", busy, 0);
    chk("R10 ready back", step_ready, 1);

    // R2: valid held across busy -> one step per BW+3 cycles
    rises = 0; prev_b = busy;
    step_valid = 1'b1; step_dir = 1'b1; sense_dir = 1'b1;
    for (int c = 0; c < 2 * (BW + 3); c++) begin
      @(negedge clk);
      if (busy && !prev_b) rises++;
      prev_b = busy;
    end
    step_valid = 1'b0;
    repeat (BW + 3) @(negedge clk);
    chk("R2 two steps taken", rises, 2);
    chk("R3 up wrap to zero, upper bits zero", pos_q, 16'h0000);

    // R1: reset after activity
    do_step(1'b1, 16'h0001, 1'b0, 1'b1, 1'b1);
    sense_dir = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 pos cleared", pos_q, 0);
    chk("R1 dir up", dir, 1);
    chk("R1 busy low", busy, 0);
    chk("R1 ready high", step_ready, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule